// File: doc/BRIEF.md
# Banked Activation Scratchpad with Asymmetric Ports

This block is the on-chip store for feature-map tiles that two compute engines share. Storage is split into equal banks, each one row of 16 bytes wide. A wide engine side has two independent read ports and one write port. Each of these ports names a start bank and a span of one to four banks, and moves up to 64 bytes per cycle. A narrow engine side has one read port and one write port, and each of them always covers exactly one bank. Every write carries byte enables, one per byte lane.

A DMA channel moves bulk data between global memory and this store. It takes over one side through an ownership flag for that side. While a side is owned, the requests of that side's engine are dropped, and their valid or acknowledge outputs stay low. The hardware does not detect or resolve colliding accesses. The compiled schedule keeps simultaneous accesses on separate banks. If two writes do land in the same bank, a fixed static mux order decides, and software may not rely on that order.

Reads return data one cycle after the request, and writes are acknowledged one cycle after the request. The bank depth is a parameter. The default depth is kept small, and a depth of 1024 gives the full 256 kB with 16 banks.

Top module: `act_scratchpad`

## Requirements
- R1: During reset, and in the first cycle after reset, every valid and acknowledge output (ra0_rvalid, ra1_rvalid, nr_rvalid, wa_ack, nw_ack, dma_rvalid, dma_wack) is low.
- R2: A wide read has a start bank b, a row r and a span code s, where code s means s+1 banks. One cycle later the matching rvalid is high. Lane k of the read data (bits k*128+127 down to k*128) holds row r of bank (b+k) mod NUM_BANKS for every k up to s. Every lane above s reads as zero.
- R3: A wide access that runs past the last bank wraps to bank 0 and stays on the same row.
- R4: In a wide write, byte j of lane k is written only when wa_be bit k*16+j is set. Bytes whose enable is clear keep their old value, and so do banks outside the span. wa_ack is high one cycle later.
- R5: A narrow read returns one full bank row on nr_rdata one cycle later, with nr_rvalid high. A narrow write stores nw_data under its 16 byte enables and raises nw_ack one cycle later.
- R6: The two wide read ports serve different banks in the same cycle, and each returns its own data.
- R7: When a read and a write hit the same bank and row in the same cycle, the read returns the data held before the write.
- R8: While dma_own_w is high, requests on ra0, ra1 and wa are ignored. No bank changes, and ra0_rvalid, ra1_rvalid and wa_ack are low in the next cycle.
- R9: While dma_own_n is high, requests on nr and nw are ignored. No bank changes, and nr_rvalid and nw_ack are low in the next cycle.
- R10: With dma_own_w high, a DMA request uses the wide path with its start bank and span. dma_we=1 writes under dma_be and raises dma_wack one cycle later. dma_we=0 returns the packed data on dma_rdata with dma_rvalid one cycle later.
- R11: With dma_own_n high and dma_own_w low, a DMA request uses the narrow path. The span is ignored, only lane 0 of dma_wdata and dma_be is used, and on a read the lanes of dma_rdata above lane 0 are zero. When both flags are high, the wide path is used.
- R12: A DMA request made while neither side is owned is dropped. Nothing is written, and dma_rvalid and dma_wack stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra0_req | input | 1 | Wide read port 0 request |
| ra0_bank | input | 4 | Wide read port 0 start bank |
| ra0_row | input | 4 | Wide read port 0 row |
| ra0_span | input | 2 | Wide read port 0 span code (banks minus one) |
| ra0_rvalid | output | 1 | Wide read port 0 data valid |
| ra0_rdata | output | 512 | Wide read port 0 packed data |
| ra1_req | input | 1 | Wide read port 1 request |
| ra1_bank | input | 4 | Wide read port 1 start bank |
| ra1_row | input | 4 | Wide read port 1 row |
| ra1_span | input | 2 | Wide read port 1 span code |
| ra1_rvalid | output | 1 | Wide read port 1 data valid |
| ra1_rdata | output | 512 | Wide read port 1 packed data |
| wa_req | input | 1 | Wide write request |
| wa_bank | input | 4 | Wide write start bank |
| wa_row | input | 4 | Wide write row |
| wa_span | input | 2 | Wide write span code |
| wa_data | input | 512 | Wide write data, lane 0 lowest |
| wa_be | input | 64 | Wide write byte enables |
| wa_ack | output | 1 | Wide write served |
| nr_req | input | 1 | Narrow read request |
| nr_bank | input | 4 | Narrow read bank |
| nr_row | input | 4 | Narrow read row |
| nr_rvalid | output | 1 | Narrow read data valid |
| nr_rdata | output | 128 | Narrow read data |
| nw_req | input | 1 | Narrow write request |
| nw_bank | input | 4 | Narrow write bank |
| nw_row | input | 4 | Narrow write row |
| nw_data | input | 128 | Narrow write data |
| nw_be | input | 16 | Narrow write byte enables |
| nw_ack | output | 1 | Narrow write served |
| dma_own_w | input | 1 | DMA owns the wide side |
| dma_own_n | input | 1 | DMA owns the narrow side |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA access is a write |
| dma_bank | input | 4 | DMA start bank |
| dma_row | input | 4 | DMA row |
| dma_span | input | 2 | DMA span code (wide path only) |
| dma_wdata | input | 512 | DMA write data |
| dma_be | input | 64 | DMA write byte enables |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 512 | DMA read data |
| dma_wack | output | 1 | DMA write served |

## Verification
A fault in the per-bank write steering corrupts only rows that no port reads back at once. It shows on a later read of that bank, so the bench reads back every row it writes, both through the other side and through wrap-around spans. A stale lane tag, meaning a start bank or span code captured for the wrong cycle, garbles the packed data in the very next cycle, because the gather runs one cycle behind the bank registers. A bad ownership gate shows either as a valid or acknowledge pulse in the cycle after an owned request, or as a silently changed bank that the next read-back exposes.

// File: rtl/act_spm_pkg.sv
package act_spm_pkg;
  localparam int SPM_BANKS      = 16;
  localparam int SPM_BANK_BYTES = 16;
  localparam int SPM_DEPTH      = 16;
  localparam int SPM_MAX_SPAN   = 4;

  typedef enum logic [1:0] {
    DMA_IDLE   = 2'd0,
    DMA_WIDE   = 2'd1,
    DMA_NARROW = 2'd2
  } dma_route_e;
endpackage

// File: rtl/act_spm_bank.sv
module act_spm_bank #(
  parameter int BANK_BYTES = 16,
  parameter int BANK_DEPTH = 16,
  localparam int ROW_W  = $clog2(BANK_DEPTH),
  localparam int LANE_W = BANK_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [ROW_W-1:0]      wrow,
  input  logic [LANE_W-1:0]     wdata,
  input  logic [BANK_BYTES-1:0] wbe,
  input  logic                  re,
  input  logic [ROW_W-1:0]      rrow,
  output logic [LANE_W-1:0]     rdata
);
  logic [BANK_BYTES-1:0][7:0] mem [BANK_DEPTH];

  // read-first: a same-row write becomes visible one cycle later
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[rrow];
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < BANK_BYTES; j++) begin
      if (we && wbe[j]) mem[wrow][j] <= wdata[j*8 +: 8];
    end
  end
endmodule

// File: rtl/act_spm_select.sv
module act_spm_select #(
  parameter int NUM_BANKS  = 16,
  parameter int BANK_ID    = 0,
  parameter int ROW_W      = 4,
  parameter int SPAN_W     = 2,
  parameter int LANE_W     = 128,
  parameter int MAX_SPAN   = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int BB     = LANE_W / 8
) (
  input  logic                       ww_v,
  input  logic [BANK_W-1:0]          ww_bank,
  input  logic [ROW_W-1:0]           ww_row,
  input  logic [SPAN_W-1:0]          ww_span,
  input  logic [MAX_SPAN*LANE_W-1:0] ww_data,
  input  logic [MAX_SPAN*BB-1:0]     ww_be,
  input  logic                       nw_v,
  input  logic [BANK_W-1:0]          nw_bank,
  input  logic [ROW_W-1:0]           nw_row,
  input  logic [LANE_W-1:0]          nw_data,
  input  logic [BB-1:0]              nw_be,
  input  logic                       r0_v,
  input  logic [BANK_W-1:0]          r0_bank,
  input  logic [ROW_W-1:0]           r0_row,
  input  logic [SPAN_W-1:0]          r0_span,
  input  logic                       r1_v,
  input  logic [BANK_W-1:0]          r1_bank,
  input  logic [ROW_W-1:0]           r1_row,
  input  logic [SPAN_W-1:0]          r1_span,
  input  logic                       rn_v,
  input  logic [BANK_W-1:0]          rn_bank,
  input  logic [ROW_W-1:0]           rn_row,
  output logic                       we,
  output logic [ROW_W-1:0]           wrow,
  output logic [LANE_W-1:0]          wdata,
  output logic [BB-1:0]              wbe,
  output logic                       re,
  output logic [ROW_W-1:0]           rrow
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [BANK_W-1:0] ww_off, r0_off, r1_off;
  logic              ww_hit, nw_hit, r0_hit, r1_hit, rn_hit;
  logic [SPAN_W-1:0] ww_lane;

  // distance from start bank, modulo the bank count
  assign ww_off  = MY_BANK - ww_bank;
  assign r0_off  = MY_BANK - r0_bank;
  assign r1_off  = MY_BANK - r1_bank;
  assign ww_hit  = ww_v && (int'(ww_off) <= int'(ww_span));
  assign r0_hit  = r0_v && (int'(r0_off) <= int'(r0_span));
  assign r1_hit  = r1_v && (int'(r1_off) <= int'(r1_span));
  assign nw_hit  = nw_v && (nw_bank == MY_BANK);
  assign rn_hit  = rn_v && (rn_bank == MY_BANK);
  assign ww_lane = ww_off[SPAN_W-1:0];

  always_comb begin
    we    = 1'b0;
    wrow  = ww_row;
    wdata = ww_data[ww_lane*LANE_W +: LANE_W];
    wbe   = ww_be[ww_lane*BB +: BB];
    if (ww_hit) begin
      we = 1'b1;
    end else if (nw_hit) begin
      we    = 1'b1;
      wrow  = nw_row;
      wdata = nw_data;
      wbe   = nw_be;
    end
  end

  always_comb begin
    re   = r0_hit | r1_hit | rn_hit;
    rrow = rn_row;
    if (r0_hit)      rrow = r0_row;
    else if (r1_hit) rrow = r1_row;
  end
endmodule

// File: rtl/act_spm_gather.sv
module act_spm_gather #(
  parameter int NUM_BANKS = 16,
  parameter int LANE_W    = 128,
  parameter int LANES     = 4,
  parameter int SPAN_W    = 2,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS*LANE_W-1:0] bank_q,
  input  logic [BANK_W-1:0]           start,
  input  logic [SPAN_W-1:0]           span,
  output logic [LANES*LANE_W-1:0]     data
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BANK_W-1:0] idx;
    assign idx = start + BANK_W'(k);
    assign data[k*LANE_W +: LANE_W] =
      (k <= int'(span)) ? bank_q[idx*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/act_scratchpad.sv
module act_scratchpad
  import act_spm_pkg::*;
#(
  parameter int NUM_BANKS  = SPM_BANKS,
  parameter int BANK_BYTES = SPM_BANK_BYTES,
  parameter int BANK_DEPTH = SPM_DEPTH,
  parameter int MAX_SPAN   = SPM_MAX_SPAN,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(BANK_DEPTH),
  localparam int SPAN_W = $clog2(MAX_SPAN),
  localparam int LANE_W = BANK_BYTES * 8,
  localparam int WIDE_W = LANE_W * MAX_SPAN,
  localparam int WBE_W  = BANK_BYTES * MAX_SPAN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ra0_req,
  input  logic [BANK_W-1:0]     ra0_bank,
  input  logic [ROW_W-1:0]      ra0_row,
  input  logic [SPAN_W-1:0]     ra0_span,
  output logic                  ra0_rvalid,
  output logic [WIDE_W-1:0]     ra0_rdata,
  input  logic                  ra1_req,
  input  logic [BANK_W-1:0]     ra1_bank,
  input  logic [ROW_W-1:0]      ra1_row,
  input  logic [SPAN_W-1:0]     ra1_span,
  output logic                  ra1_rvalid,
  output logic [WIDE_W-1:0]     ra1_rdata,
  input  logic                  wa_req,
  input  logic [BANK_W-1:0]     wa_bank,
  input  logic [ROW_W-1:0]      wa_row,
  input  logic [SPAN_W-1:0]     wa_span,
  input  logic [WIDE_W-1:0]     wa_data,
  input  logic [WBE_W-1:0]      wa_be,
  output logic                  wa_ack,
  input  logic                  nr_req,
  input  logic [BANK_W-1:0]     nr_bank,
  input  logic [ROW_W-1:0]      nr_row,
  output logic                  nr_rvalid,
  output logic [LANE_W-1:0]     nr_rdata,
  input  logic                  nw_req,
  input  logic [BANK_W-1:0]     nw_bank,
  input  logic [ROW_W-1:0]      nw_row,
  input  logic [LANE_W-1:0]     nw_data,
  input  logic [BANK_BYTES-1:0] nw_be,
  output logic                  nw_ack,
  input  logic                  dma_own_w,
  input  logic                  dma_own_n,
  input  logic                  dma_req,
  input  logic                  dma_we,
  input  logic [BANK_W-1:0]     dma_bank,
  input  logic [ROW_W-1:0]      dma_row,
  input  logic [SPAN_W-1:0]     dma_span,
  input  logic [WIDE_W-1:0]     dma_wdata,
  input  logic [WBE_W-1:0]      dma_be,
  output logic                  dma_rvalid,
  output logic [WIDE_W-1:0]     dma_rdata,
  output logic                  dma_wack
);
  // ---------------- DMA routing ----------------
  dma_route_e route, route_q;
  always_comb begin
    if (!dma_req)       route = DMA_IDLE;
    else if (dma_own_w) route = DMA_WIDE;
    else if (dma_own_n) route = DMA_NARROW;
    else                route = DMA_IDLE;
  end

  logic dma_w_rd, dma_w_wr, dma_n_rd, dma_n_wr;
  assign dma_w_rd = (route == DMA_WIDE)   && !dma_we;
  assign dma_w_wr = (route == DMA_WIDE)   &&  dma_we;
  assign dma_n_rd = (route == DMA_NARROW) && !dma_we;
  assign dma_n_wr = (route == DMA_NARROW) &&  dma_we;

  logic eng_ra0, eng_ra1, eng_wa, eng_nr, eng_nw;
  assign eng_ra0 = ra0_req && !dma_own_w;
  assign eng_ra1 = ra1_req && !dma_own_w;
  assign eng_wa  = wa_req  && !dma_own_w;
  assign eng_nr  = nr_req  && !dma_own_n;
  assign eng_nw  = nw_req  && !dma_own_n;

  // ---------------- path multiplexing ----------------
  logic              p0_v;
  logic [BANK_W-1:0] p0_bank;
  logic [ROW_W-1:0]  p0_row;
  logic [SPAN_W-1:0] p0_span;
  assign p0_v    = dma_w_rd | eng_ra0;
  assign p0_bank = dma_w_rd ? dma_bank : ra0_bank;
  assign p0_row  = dma_w_rd ? dma_row  : ra0_row;
  assign p0_span = dma_w_rd ? dma_span : ra0_span;

  logic              pw_v;
  logic [BANK_W-1:0] pw_bank;
  logic [ROW_W-1:0]  pw_row;
  logic [SPAN_W-1:0] pw_span;
  logic [WIDE_W-1:0] pw_data;
  logic [WBE_W-1:0]  pw_be;
  assign pw_v    = dma_w_wr | eng_wa;
  assign pw_bank = dma_w_wr ? dma_bank  : wa_bank;
  assign pw_row  = dma_w_wr ? dma_row   : wa_row;
  assign pw_span = dma_w_wr ? dma_span  : wa_span;
  assign pw_data = dma_w_wr ? dma_wdata : wa_data;
  assign pw_be   = dma_w_wr ? dma_be    : wa_be;

  logic              pn_v;
  logic [BANK_W-1:0] pn_bank;
  logic [ROW_W-1:0]  pn_row;
  assign pn_v    = dma_n_rd | eng_nr;
  assign pn_bank = dma_n_rd ? dma_bank : nr_bank;
  assign pn_row  = dma_n_rd ? dma_row  : nr_row;

  logic                  pnw_v;
  logic [BANK_W-1:0]     pnw_bank;
  logic [ROW_W-1:0]      pnw_row;
  logic [LANE_W-1:0]     pnw_data;
  logic [BANK_BYTES-1:0] pnw_be;
  assign pnw_v    = dma_n_wr | eng_nw;
  assign pnw_bank = dma_n_wr ? dma_bank : nw_bank;
  assign pnw_row  = dma_n_wr ? dma_row  : nw_row;
  assign pnw_data = dma_n_wr ? dma_wdata[LANE_W-1:0] : nw_data;
  assign pnw_be   = dma_n_wr ? dma_be[BANK_BYTES-1:0] : nw_be;

  // ---------------- banks ----------------
  logic [NUM_BANKS*LANE_W-1:0] bank_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic                  we, re;
    logic [ROW_W-1:0]      wrow, rrow;
    logic [LANE_W-1:0]     wdata;
    logic [BANK_BYTES-1:0] wbe;

    act_spm_select #(
      .NUM_BANKS(NUM_BANKS), .BANK_ID(b), .ROW_W(ROW_W),
      .SPAN_W(SPAN_W), .LANE_W(LANE_W), .MAX_SPAN(MAX_SPAN)
    ) u_sel (
      .ww_v(pw_v), .ww_bank(pw_bank), .ww_row(pw_row), .ww_span(pw_span),
      .ww_data(pw_data), .ww_be(pw_be),
      .nw_v(pnw_v), .nw_bank(pnw_bank), .nw_row(pnw_row),
      .nw_data(pnw_data), .nw_be(pnw_be),
      .r0_v(p0_v), .r0_bank(p0_bank), .r0_row(p0_row), .r0_span(p0_span),
      .r1_v(eng_ra1), .r1_bank(ra1_bank), .r1_row(ra1_row), .r1_span(ra1_span),
      .rn_v(pn_v), .rn_bank(pn_bank), .rn_row(pn_row),
      .we(we), .wrow(wrow), .wdata(wdata), .wbe(wbe),
      .re(re), .rrow(rrow)
    );

    act_spm_bank #(
      .BANK_BYTES(BANK_BYTES), .BANK_DEPTH(BANK_DEPTH)
    ) u_bank (
      .clk(clk), .we(we), .wrow(wrow), .wdata(wdata), .wbe(wbe),
      .re(re), .rrow(rrow), .rdata(bank_q[b*LANE_W +: LANE_W])
    );
  end

  // ---------------- lane tags for the gather stage ----------------
  logic [BANK_W-1:0] p0_bank_q, p1_bank_q, pn_bank_q;
  logic [SPAN_W-1:0] p0_span_q, p1_span_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_bank_q  <= '0;
      p0_span_q  <= '0;
      p1_bank_q  <= '0;
      p1_span_q  <= '0;
      pn_bank_q  <= '0;
      route_q    <= DMA_IDLE;
      ra0_rvalid <= 1'b0;
      ra1_rvalid <= 1'b0;
      wa_ack     <= 1'b0;
      nr_rvalid  <= 1'b0;
      nw_ack     <= 1'b0;
      dma_rvalid <= 1'b0;
      dma_wack   <= 1'b0;
    end else begin
      p0_bank_q  <= p0_bank;
      p0_span_q  <= p0_span;
      p1_bank_q  <= ra1_bank;
      p1_span_q  <= ra1_span;
      pn_bank_q  <= pn_bank;
      route_q    <= route;
      ra0_rvalid <= eng_ra0;
      ra1_rvalid <= eng_ra1;
      wa_ack     <= eng_wa;
      nr_rvalid  <= eng_nr;
      nw_ack     <= eng_nw;
      dma_rvalid <= dma_w_rd | dma_n_rd;
      dma_wack   <= dma_w_wr | dma_n_wr;
    end
  end

  logic [WIDE_W-1:0] g0_data;
  logic [LANE_W-1:0] gn_data;

  act_spm_gather #(
    .NUM_BANKS(NUM_BANKS), .LANE_W(LANE_W), .LANES(MAX_SPAN), .SPAN_W(SPAN_W)
  ) u_g0 (.bank_q(bank_q), .start(p0_bank_q), .span(p0_span_q), .data(g0_data));

  act_spm_gather #(
    .NUM_BANKS(NUM_BANKS), .LANE_W(LANE_W), .LANES(MAX_SPAN), .SPAN_W(SPAN_W)
  ) u_g1 (.bank_q(bank_q), .start(p1_bank_q), .span(p1_span_q), .data(ra1_rdata));

  act_spm_gather #(
    .NUM_BANKS(NUM_BANKS), .LANE_W(LANE_W), .LANES(1), .SPAN_W(1)
  ) u_gn (.bank_q(bank_q), .start(pn_bank_q), .span(1'b0), .data(gn_data));

  assign ra0_rdata = g0_data;
  assign nr_rdata  = gn_data;
  assign dma_rdata = (route_q == DMA_WIDE) ? g0_data
                                           : {{(WIDE_W-LANE_W){1'b0}}, gn_data};
endmodule

// File: rtl/act_scratchpad_chk.sv
module act_scratchpad_chk #(
  parameter int SPAN_W = 2,
  parameter int LANE_W = 128,
  parameter int WIDE_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              ra0_req,
  input logic [SPAN_W-1:0] ra0_span,
  input logic              ra0_rvalid,
  input logic [WIDE_W-1:0] ra0_rdata,
  input logic              ra1_req,
  input logic              ra1_rvalid,
  input logic              wa_ack,
  input logic              nr_rvalid,
  input logic              nw_ack,
  input logic              dma_own_w,
  input logic              dma_own_n,
  input logic              dma_req,
  input logic              dma_rvalid,
  input logic              dma_wack
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !ra0_rvalid && !ra1_rvalid && !wa_ack && !nr_rvalid
                   && !nw_ack && !dma_rvalid && !dma_wack);

  // R8
  wide_owned_chk: assert property (@(posedge clk) disable iff (rst)
    dma_own_w |=> !ra0_rvalid && !ra1_rvalid && !wa_ack);

  // R9
  narrow_owned_chk: assert property (@(posedge clk) disable iff (rst)
    dma_own_n |=> !nr_rvalid && !nw_ack);

  // R6
  rd1_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ra1_rvalid |-> $past(ra1_req));

  // R2
  rd0_origin_chk: assert property (@(posedge clk) disable iff (rst)
    ra0_rvalid |-> $past(ra0_req));

  // R2
  upper_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ra0_rvalid && ($past(ra0_span) == '0) |-> ra0_rdata[WIDE_W-1:LANE_W] == '0);

  // R12
  dma_unowned_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_own_w && !dma_own_n |=> !dma_rvalid && !dma_wack);

  // R10
  dma_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dma_rvalid |-> !dma_wack);
endmodule

bind act_scratchpad act_scratchpad_chk #(
  .SPAN_W(SPAN_W), .LANE_W(LANE_W), .WIDE_W(WIDE_W)
) u_chk (
  .clk(clk), .rst(rst),
  .ra0_req(ra0_req), .ra0_span(ra0_span), .ra0_rvalid(ra0_rvalid),
  .ra0_rdata(ra0_rdata), .ra1_req(ra1_req), .ra1_rvalid(ra1_rvalid),
  .wa_ack(wa_ack), .nr_rvalid(nr_rvalid), .nw_ack(nw_ack),
  .dma_own_w(dma_own_w), .dma_own_n(dma_own_n), .dma_req(dma_req),
  .dma_rvalid(dma_rvalid), .dma_wack(dma_wack)
);

// File: tb/tb_act_scratchpad.sv
module tb_act_scratchpad;
  localparam int NB = 16, BB = 16, DEPTH = 16, SPANS = 4;
  localparam int LW = BB * 8, WW = LW * SPANS, WBE = BB * SPANS;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic          ra0_req = 0, ra1_req = 0, wa_req = 0, nr_req = 0, nw_req = 0;
  logic [3:0]    ra0_bank = 0, ra0_row = 0, ra1_bank = 0, ra1_row = 0;
  logic [1:0]    ra0_span = 0, ra1_span = 0, wa_span = 0, dma_span = 0;
  logic [3:0]    wa_bank = 0, wa_row = 0, nr_bank = 0, nr_row = 0, nw_bank = 0, nw_row = 0;
  logic [WW-1:0] wa_data = 0, dma_wdata = 0;
  logic [WBE-1:0] wa_be = 0, dma_be = 0;
  logic [LW-1:0] nw_data = 0;
  logic [BB-1:0] nw_be = 0;
  logic          dma_own_w = 0, dma_own_n = 0, dma_req = 0, dma_we = 0;
  logic [3:0]    dma_bank = 0, dma_row = 0;

  logic          ra0_rvalid, ra1_rvalid, wa_ack, nr_rvalid, nw_ack, dma_rvalid, dma_wack;
  logic [WW-1:0] ra0_rdata, ra1_rdata, dma_rdata;
  logic [LW-1:0] nr_rdata;

  act_scratchpad dut (.*);

  // reference model state
  logic [7:0] ref_mem [NB][DEPTH][BB];
  logic e_ra0_v, e_ra1_v, e_wa, e_nr_v, e_nw, e_dma_rv, e_dma_wa;
  logic [WW-1:0] e_ra0_d, e_ra1_d, e_dma_d;
  logic [LW-1:0] e_nr_d;
  string cur_req = "R1";
  int n_cmp = 0, n_bad = 0;

  function automatic logic [WW-1:0] rd_wide(input int b, input int r, input int s);
    logic [WW-1:0] v = '0;
    for (int k = 0; k < SPANS; k++)
      if (k <= s)
        for (int j = 0; j < BB; j++) v[k*LW + j*8 +: 8] = ref_mem[(b+k)%NB][r][j];
    return v;
  endfunction

  task automatic wr_wide(input int b, input int r, input int s,
                         input logic [WW-1:0] d, input logic [WBE-1:0] be);
    for (int k = 0; k <= s; k++)
      for (int j = 0; j < BB; j++)
        if (be[k*BB+j]) ref_mem[(b+k)%NB][r][j] = d[k*LW + j*8 +: 8];
  endtask

  task automatic model();
    logic dw, dn;
    logic [WW-1:0] nd;
    dw = dma_req && dma_own_w;
    dn = dma_req && dma_own_n && !dma_own_w;
    if (rst) begin
      {e_ra0_v, e_ra1_v, e_wa, e_nr_v, e_nw, e_dma_rv, e_dma_wa} = '0;
      return;
    end
    e_ra0_v  = ra0_req && !dma_own_w;
    e_ra1_v  = ra1_req && !dma_own_w;
    e_wa     = wa_req && !dma_own_w;
    e_nr_v   = nr_req && !dma_own_n;
    e_nw     = nw_req && !dma_own_n;
    e_dma_rv = (dw || dn) && !dma_we;
    e_dma_wa = (dw || dn) && dma_we;
    e_ra0_d  = rd_wide(ra0_bank, ra0_row, ra0_span);
    e_ra1_d  = rd_wide(ra1_bank, ra1_row, ra1_span);
    nd       = rd_wide(nr_bank, nr_row, 0);
    e_nr_d   = nd[LW-1:0];
    e_dma_d  = dw ? rd_wide(dma_bank, dma_row, dma_span) : rd_wide(dma_bank, dma_row, 0);
    if (e_wa) wr_wide(wa_bank, wa_row, wa_span, wa_data, wa_be);
    if (dw && dma_we) wr_wide(dma_bank, dma_row, dma_span, dma_wdata, dma_be);
    if (e_nw) wr_wide(nw_bank, nw_row, 0, {{(WW-LW){1'b0}}, nw_data}, {{(WBE-BB){1'b0}}, nw_be});
    if (dn && dma_we) wr_wide(dma_bank, dma_row, 0, dma_wdata, dma_be);
  endtask

  task automatic chk(input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("ra0_rvalid", WW'(ra0_rvalid), WW'(e_ra0_v));
    chk("ra1_rvalid", WW'(ra1_rvalid), WW'(e_ra1_v));
    chk("wa_ack", WW'(wa_ack), WW'(e_wa));
    chk("nr_rvalid", WW'(nr_rvalid), WW'(e_nr_v));
    chk("nw_ack", WW'(nw_ack), WW'(e_nw));
    chk("dma_rvalid", WW'(dma_rvalid), WW'(e_dma_rv));
    chk("dma_wack", WW'(dma_wack), WW'(e_dma_wa));
    if (e_ra0_v)  chk("ra0_rdata", ra0_rdata, e_ra0_d);
    if (e_ra1_v)  chk("ra1_rdata", ra1_rdata, e_ra1_d);
    if (e_nr_v)   chk("nr_rdata", WW'(nr_rdata), WW'(e_nr_d));
    if (e_dma_rv) chk("dma_rdata", dma_rdata, e_dma_d);
  endtask

  task automatic tick();
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    {ra0_req, ra1_req, wa_req, nr_req, nw_req, dma_req, dma_we, dma_own_w, dma_own_n} = '0;
  endtask

  function automatic logic [WW-1:0] rnd();
    logic [WW-1:0] v;
    for (int i = 0; i < WW/32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic rd0(input int b, input int r, input int s);
    idle(); ra0_req = 1; ra0_bank = 4'(b); ra0_row = 4'(r); ra0_span = 2'(s); tick();
  endtask

  task automatic nrd(input int b, input int r);
    idle(); nr_req = 1; nr_bank = 4'(b); nr_row = 4'(r); tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL %s watchdog actual=timeout expected=completion", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < DEPTH; r++)
        for (int j = 0; j < BB; j++) ref_mem[b][r][j] = 8'h00;
    // R1: reset state
    cur_req = "R1";
    rst = 1; idle();
    repeat (3) tick();
    rst = 0; tick();
    // R5: narrow fill of every bank and row, then read back through the narrow port
    cur_req = "R5";
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < DEPTH; r++) begin
        idle(); nw_req = 1; nw_bank = 4'(b); nw_row = 4'(r);
        nw_data = rnd()[LW-1:0]; nw_be = '1; tick();
      end
    for (int b = 0; b < NB; b++) nrd(b, b);
    idle(); nw_req = 1; nw_bank = 2; nw_row = 3; nw_data = rnd()[LW-1:0]; nw_be = 16'h0F0F; tick();
    nrd(2, 3);
    // R2: wide reads of every span from several start banks
    cur_req = "R2";
    for (int s = 0; s < SPANS; s++)
      for (int b = 0; b < 12; b += 3) rd0(b, (b + s) % DEPTH, s);
    // R4: wide write with sparse byte enables
    cur_req = "R4";
    idle(); wa_req = 1; wa_bank = 5; wa_row = 2; wa_span = 3;
    wa_data = rnd(); wa_be = 64'hF00F_0FF0_AAAA_5555; tick();
    rd0(4, 2, 3); rd0(5, 2, 3); nrd(9, 2);
    idle(); wa_req = 1; wa_bank = 0; wa_row = 7; wa_span = 1; wa_data = rnd(); wa_be = '1; tick();
    rd0(0, 7, 3);
    // R3: wrap past the last bank
    cur_req = "R3";
    idle(); wa_req = 1; wa_bank = 14; wa_row = 9; wa_span = 3; wa_data = rnd(); wa_be = '1; tick();
    rd0(15, 9, 3); rd0(14, 9, 2); nrd(0, 9); nrd(1, 9);
    // R6: both wide read ports in the same cycle
    cur_req = "R6";
    for (int i = 0; i < 4; i++) begin
      idle(); ra0_req = 1; ra0_bank = 4'(i); ra0_row = 4'(i); ra0_span = 3;
      ra1_req = 1; ra1_bank = 4'(8 + i); ra1_row = 4'(i + 5); ra1_span = 2'(i); tick();
    end
    // R7: read and write to the same bank and row in one cycle
    cur_req = "R7";
    idle(); ra0_req = 1; ra0_bank = 3; ra0_row = 1; ra0_span = 0;
    nw_req = 1; nw_bank = 3; nw_row = 1; nw_data = rnd()[LW-1:0]; nw_be = '1; tick();
    idle(); nr_req = 1; nr_bank = 10; nr_row = 4;
    wa_req = 1; wa_bank = 10; wa_row = 4; wa_span = 0; wa_data = rnd(); wa_be = '1; tick();
    rd0(3, 1, 0); nrd(10, 4);
    // R8: wide side owned, engine requests ignored
    cur_req = "R8";
    idle(); dma_own_w = 1; ra0_req = 1; ra1_req = 1; ra1_bank = 8;
    wa_req = 1; wa_bank = 4; wa_row = 6; wa_span = 3; wa_data = rnd(); wa_be = '1; tick();
    rd0(4, 6, 3);
    // R9: narrow side owned, engine requests ignored
    cur_req = "R9";
    idle(); dma_own_n = 1; nr_req = 1; nr_bank = 1;
    nw_req = 1; nw_bank = 6; nw_row = 6; nw_data = rnd()[LW-1:0]; nw_be = '1; tick();
    nrd(6, 6);
    // R10: DMA through the wide side
    cur_req = "R10";
    idle(); dma_own_w = 1; dma_req = 1; dma_we = 1; dma_bank = 13; dma_row = 11;
    dma_span = 3; dma_wdata = rnd(); dma_be = 64'h0FFF_FFFF_FFFF_FFF0; tick();
    idle(); dma_own_w = 1; dma_req = 1; dma_we = 0; dma_bank = 12; dma_row = 11; dma_span = 3; tick();
    rd0(15, 11, 1);
    // R11: DMA through the narrow side, span ignored; both owned picks wide
    cur_req = "R11";
    idle(); dma_own_n = 1; dma_req = 1; dma_we = 1; dma_bank = 7; dma_row = 12;
    dma_span = 3; dma_wdata = rnd(); dma_be = '1; tick();
    idle(); dma_own_n = 1; dma_req = 1; dma_we = 0; dma_bank = 7; dma_row = 12; dma_span = 3; tick();
    rd0(7, 12, 1);
    idle(); dma_own_n = 1; dma_own_w = 1; dma_req = 1; dma_we = 0;
    dma_bank = 6; dma_row = 12; dma_span = 2; tick();
    // R12: DMA without ownership is dropped
    cur_req = "R12";
    idle(); dma_req = 1; dma_we = 1; dma_bank = 2; dma_row = 13; dma_span = 3;
    dma_wdata = rnd(); dma_be = '1; tick();
    rd0(2, 13, 3);
    idle(); tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule